// File: doc/BRIEF.md
# Four-Phase Handshake Debug Register Target

This block is a small bank of data registers on a debug-module bus. It sits in the system clock domain and is accessed with a return-to-zero request/acknowledge handshake. The master raises `req_i` together with the address, the write flag and the write data. The target performs exactly one access and raises `ack_o`. It holds `ack_o` high, and keeps its read data steady, until the master drops `req_i`. After that the target lowers `ack_o` and waits one release cycle before it accepts the next request.

A master that stalls can leave `req_i` high for any number of cycles. The target keeps acknowledging and never repeats the access. Addresses beyond the implemented bank read as zero and absorb writes. These accesses still complete the handshake, so the master never hangs on a stray address.

Top module: `dbg_reg_target`

## Requirements
- R1: When `req_i` is sampled high at a clock edge while the target is idle, address, write flag and write data are captured at that same edge. `ack_o` is high from that edge on.
- R2: Once high, `ack_o` stays high for as long as `req_i` stays high, however long that is.
- R3: For a read handshake, `rdata_o` takes the content of the addressed register as it stood at the accepting edge. It stays unchanged while `ack_o` is high, and until the next read handshake is accepted. Changes on `addr_i` or `wdata_i` after acceptance have no effect.
- R4: `wr_i` = 1 marks a write. A write handshake updates the addressed register exactly once, at the accepting edge. Holding `req_i` high and changing `wdata_i` afterwards does not alter the register.
- R5: `ack_o` goes low at the first edge where `req_i` is sampled low. The following edge is a release cycle in which a high `req_i` is not accepted. The earliest new acceptance is the edge after that.
- R6: `ADDR_W` (default 8) and `DATA_W` (default 32) set the bus widths. `NUM_REGS` (default 8) registers sit at addresses 0 through `NUM_REGS`-1, and each holds the last value written to it.
- R7: A read of an address at or above `NUM_REGS` returns zero. A write there changes no register. Both are acknowledged like any other access.
- R8: A synchronous active-high `rst` clears every register, `rdata_o` and `ack_o`, and returns the target to idle.
- R9: A write handshake leaves `rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request from the master, four-phase |
| wr_i | input | 1 | 1 = write, 0 = read; valid with the rising request |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | Acknowledge, held until the request drops |
| rdata_o | output | DATA_W | Read data, held between read handshakes |

## Verification
The register update from a write and the read-data capture of a read both happen at an accepting edge. The sharpest collision is therefore a write to a register, followed at the minimum release gap by a read of the same register. That read must return the freshly written value, while the earlier write must not disturb the held `rdata_o`. The bench provokes this case with back-to-back handshakes on a small address range and one-cycle gaps. It checks every read against its own register model, and checks after each write that `rdata_o` still equals the last read result. Long holds, during which `addr_i` and `wdata_i` are scrambled, confirm that neither a repeated write nor a drifting read value shows up.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_ACK     = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  // True when an address falls inside the implemented bank.
  function automatic logic slot_hit(input int unsigned addr, input int unsigned nregs);
    return addr < nregs;
  endfunction

  // Address decode of one slot.
  function automatic logic slot_sel(input int unsigned addr, input int unsigned slot);
    return addr == slot;
  endfunction

endpackage

// File: rtl/dbgt_hs_fsm.sv
module dbgt_hs_fsm
  import dbgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic accept_o,
  output logic ack_o
);

  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE:    if (req_i)  state_d = HS_ACK;
      HS_ACK:     if (!req_i) state_d = HS_RELEASE;
      HS_RELEASE: state_d = HS_IDLE;
      default:    state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_IDLE;
    else     state_q <= state_d;
  end

  // Acceptance happens only from idle; release swallows any request.
  assign accept_o = (state_q == HS_IDLE) && req_i;
  assign ack_o    = (state_q == HS_ACK);

endmodule

// File: rtl/dbgt_regbank.sv
module dbgt_regbank
  import dbgt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] slot_rd;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    logic              sel;

    assign sel = slot_sel(int'(addr_i), i);

    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (we_i && sel) q <= wdata_i;
    end

    assign slot_rd[i] = sel ? q : '0;
  end

  // OR of the decoded slots; an address outside the bank selects none.
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) rdata_o = rdata_o | slot_rd[i];
  end

endmodule

// File: rtl/dbgt_rd_hold.sv
module dbgt_rd_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target
  import dbgt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);

  // Named internal events, visible to the bound checker.
  logic              accept_evt;
  logic              wr_evt;
  logic              rd_evt;
  logic              addr_hit;
  logic [DATA_W-1:0] bank_rdata;

  dbgt_hs_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .accept_o (accept_evt),
    .ack_o    (ack_o)
  );

  assign wr_evt   = accept_evt && wr_i;
  assign rd_evt   = accept_evt && !wr_i;
  assign addr_hit = slot_hit(int'(addr_i), NUM_REGS);

  dbgt_regbank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_evt && addr_hit),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (bank_rdata)
  );

  dbgt_rd_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (rd_evt),
    .d_i    (bank_rdata),
    .q_o    (rdata_o)
  );

endmodule

// File: rtl/dbgt_chk.sv
module dbgt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              accept_evt,
  input logic              wr_evt,
  input logic              rd_evt
);

  // R1
  accept_ack_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> ack_o);

  // R1
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(accept_evt));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> ack_o);

  // R3
  rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> $stable(rdata_o));

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !wr_evt);

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !req_i) |=> !ack_o);

  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !accept_evt);

  // R9
  write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> $stable(rdata_o));

  // R4
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_evt, rd_evt}));

endmodule

bind dbg_reg_target dbgt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .ack_o      (ack_o),
  .rdata_o    (rdata_o),
  .accept_evt (accept_evt),
  .wr_evt     (wr_evt),
  .rd_evt     (rd_evt)
);

// File: tb/tb_dbg_reg_target.sv
`timescale 1ns/1ps
module tb_dbg_reg_target;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_i;
  logic          wr_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic          ack_o;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];
  logic [DW-1:0] last_rd;

  always #4 clk = ~clk;

  dbg_reg_target #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (int'(a) < NR) return model[a];
    return '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    last_rd = '0;
    check("R8 ack after reset", {31'd0, ack_o}, '0);
    check("R8 rdata after reset", rdata_o, '0);
  endtask

  // One full handshake; called just after a negedge with the target idle.
  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int hold, input int gap);
    logic [DW-1:0] held;
    req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    check("R5 idle before accept", {31'd0, ack_o}, '0);
    @(negedge clk);
    check("R1 ack after accept", {31'd0, ack_o}, 32'd1);
    if (!w) begin
      last_rd = exp_read(a);
      check(int'(a) < NR ? "R3 R6 read data" : "R7 unimplemented read", rdata_o, last_rd);
    end else begin
      check("R9 write keeps rdata", rdata_o, last_rd);
      if (int'(a) < NR) model[a] = d;
    end
    held = rdata_o;
    for (int h = 0; h < hold; h++) begin
      addr_i = ~a; wdata_i = ~d;
      @(negedge clk);
      check("R2 ack held", {31'd0, ack_o}, 32'd1);
      check("R3 rdata stable", rdata_o, held);
    end
    req_i = 1'b0; wr_i = $urandom % 2; addr_i = $urandom; wdata_i = $urandom;
    @(negedge clk);
    check("R5 ack drop", {31'd0, ack_o}, '0);
    check("R3 rdata held after drop", rdata_o, held);
    repeat (gap) @(negedge clk);
  endtask

  // Request raised in the release cycle must wait one more edge.
  task automatic early_req(input logic [AW-1:0] a);
    xfer(1'b0, a, '0, 0, 0);
    req_i = 1'b1; wr_i = 1'b0; addr_i = a;
    @(negedge clk);
    check("R5 not accepted in release", {31'd0, ack_o}, '0);
    @(negedge clk);
    check("R5 accepted after release", {31'd0, ack_o}, 32'd1);
    last_rd = exp_read(a);
    check("R3 read after early request", rdata_o, last_rd);
    req_i = 1'b0;
    @(negedge clk);
    check("R5 ack drop", {31'd0, ack_o}, '0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R8: every register reads zero after reset
    for (int i = 0; i < NR; i++) xfer(1'b0, AW'(i), '0, 0, 1);

    // R4 write-then-read collision at minimum gap
    xfer(1'b1, 8'd3, 32'hCAFE_0003, 0, 1);
    xfer(1'b0, 8'd3, '0, 0, 1);
    // R4 long hold with scrambled data must write once
    xfer(1'b1, 8'd5, 32'h1234_5678, 40, 1);
    xfer(1'b0, 8'd5, '0, 3, 1);
    xfer(1'b0, 8'd2, '0, 2, 1);
    // R7 unimplemented accesses, highest address
    xfer(1'b1, 8'hFF, 32'hDEAD_BEEF, 1, 1);
    xfer(1'b1, 8'(NR), 32'h0BAD_0BAD, 0, 1);
    for (int i = 0; i < NR; i++) xfer(1'b0, AW'(i), '0, 0, 1);
    xfer(1'b0, 8'(NR), '0, 0, 2);
    // R5 request raised during release
    early_req(8'd5);

    // R6 randomized mix against the model
    for (int n = 0; n < 400; n++) begin
      logic          w;
      logic [AW-1:0] a;
      int            hold;
      w    = ($urandom % 2) == 1;
      a    = ($urandom % 16 == 0) ? AW'($urandom) : AW'($urandom % (NR + 3));
      hold = ($urandom % 20 == 0) ? 30 : int'($urandom % 5);
      xfer(w, a, $urandom, hold, 1 + int'($urandom % 3));
    end

    // R8 reset mid-run clears the bank
    do_reset();
    for (int i = 0; i < NR; i++) xfer(1'b0, AW'(i), '0, 0, 1);

    summary();
    $finish;
  end

endmodule